// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This unit turns an integer operand into an IEEE 754 value. One datapath covers eight
variants: the source may be 32 or 64 bits wide, read as two's complement or as unsigned,
and the result may be binary64 or binary32. A binary32 result is always returned
re-expressed exactly in binary64 register layout, so the result port is 64 bits wide in
every case. Rounding always follows a 2-bit mode supplied from the floating-point status
register. Truncation is never forced.

The integer is sign- or zero-extended and its magnitude is taken. A leading-zero count
normalises it, and two rounders produce a 53-bit and a 24-bit significand from guard,
round and sticky information. The selected result, an inexact flag and two class flags
(zero, negative) are registered once and appear one cycle after a valid operand. Overflow
cannot arise from these source widths, so no overflow flag exists.

Top module: `i2f_conv`

## Requirements
- R1: A result, with `out_valid` high, appears on the clock edge after `in_valid` is sampled high. `out_valid` is low after a cycle without `in_valid` and is low after reset.
- R2: With `src_wide` low, only `operand[31:0]` is converted and `operand[63:32]` has no effect on any output.
- R3: With `src_signed` high, the selected source is two's complement; with it low, the source is unsigned and the result sign bit (bit 63) is 0.
- R4: With `dst_single` low, the result is the binary64 value of the integer rounded to a 53-bit significand (sign bit 63, biased exponent bits 62:52 with bias 1023, fraction bits 51:0).
- R5: With `dst_single` high, the value is rounded to a 24-bit significand and is returned in binary64 layout, so result bits 28:0 are zero.
- R6: `rmode` encodes 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R7: A zero source gives +0.0 (all 64 result bits zero), with `out_inexact` low and `out_zero` high.
- R8: `out_inexact` is high exactly when nonzero bits were dropped by rounding; a 32-bit source with a binary64 result is never inexact.
- R9: `out_zero` is high exactly when the result is zero, and `out_neg` equals result bit 63.
- R10: A carry out of the rounded significand raises the exponent by one (for example, unsigned all-ones 64-bit rounds to 2^64, encoded 0x43F0000000000000).
- R11: While `in_valid` is low, `result`, `out_inexact`, `out_zero` and `out_neg` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 64 | Integer source |
| src_wide | input | 1 | 1: 64-bit source, 0: low 32 bits |
| src_signed | input | 1 | 1: two's complement source, 0: unsigned |
| dst_single | input | 1 | 1: binary32 precision, 0: binary64 |
| rmode | input | 2 | Rounding mode from the status register |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result in binary64 register layout |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_zero | output | 1 | Result is +0.0 |
| out_neg | output | 1 | Result is negative |

## Verification
The assertions check several properties on every cycle: valid timing and the hold of the
result registers, the zero path, the cleared low fraction bits of single results, the sign
of unsigned sources, the exactness of 32-bit to binary64 conversions, consistency of the
class flags, and the exponent range. Correct rounding can only be shown by the bench's
scenarios. These cover ties, the direction taken by each mode for each sign, carry into
the exponent, and the exact bit patterns. The bench sweeps every variant and mode over
edge operands and pseudo-random operands against an arithmetic remainder model. For the
nearest mode with signed 64-bit to binary64, it also compares against the simulator's own
real conversion.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int XLEN       = 64;
  localparam int EXP_W      = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_FRAC_W = 23;
  localparam int EXP_BIAS   = 1023;
  localparam int DBL_SIG_W  = DBL_FRAC_W + 1;
  localparam int SGL_SIG_W  = SGL_FRAC_W + 1;
  localparam int CNT_W      = $clog2(XLEN);

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rmode_e;

  // Increment decision for the kept significand
  function automatic logic bump_up(rmode_e rm, logic neg, logic lsb,
                                   logic guard, logic sticky);
    logic r;
    unique case (rm)
      RM_NEAR: r = guard & (sticky | lsb);
      RM_ZERO: r = 1'b0;
      RM_POS:  r = ~neg & (guard | sticky);
      RM_NEG:  r = neg & (guard | sticky);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2f_prep.sv
module i2f_prep #(
  parameter int W = i2f_pkg::XLEN
) (
  input  logic [W-1:0] op,
  input  logic         wide,
  input  logic         sgn,
  output logic [W-1:0] mag,
  output logic         neg
);
  localparam int HW = W / 2;

  logic [W-1:0] ext;

  always_comb begin
    if (wide) begin
      ext = op;
    end else if (sgn) begin
      ext = {{HW{op[HW-1]}}, op[HW-1:0]};
    end else begin
      ext = {{HW{1'b0}}, op[HW-1:0]};
    end
    neg = sgn & ext[W-1];
    mag = neg ? (~ext + W'(1)) : ext;
  end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W  = i2f_pkg::XLEN,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Highest set bit wins; all-zero input yields 0 (handled by caller)
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int W = i2f_pkg::XLEN,
  parameter int P = i2f_pkg::DBL_SIG_W
) (
  input  logic [W-1:0] norm,
  input  logic         neg,
  input  rmode_e       rm,
  output logic [P-2:0] frac,
  output logic         carry,
  output logic         inexact
);
  localparam int DROP = W - P;

  logic [P-1:0] keep;
  logic         guard;
  logic         sticky;
  logic         up;
  logic [P:0]   sum;

  always_comb begin
    keep    = norm[W-1 -: P];
    guard   = norm[DROP-1];
    sticky  = |norm[DROP-2:0];
    inexact = guard | sticky;
    up      = bump_up(rm, neg, keep[0], guard, sticky);
    sum     = {1'b0, keep} + {{P{1'b0}}, up};
    carry   = sum[P];
    frac    = sum[P-2:0];
  end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import i2f_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] operand,
  input  logic        src_wide,
  input  logic        src_signed,
  input  logic        dst_single,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        out_inexact,
  output logic        out_zero,
  output logic        out_neg
);
  localparam int PAD_W = DBL_FRAC_W - SGL_FRAC_W;

  rmode_e                rm;
  logic [XLEN-1:0]       mag;
  logic                  neg;
  logic [CNT_W-1:0]      lz;
  logic [XLEN-1:0]       norm;
  logic                  is_zero;
  logic [DBL_FRAC_W-1:0] d_frac;
  logic                  d_carry, d_inx;
  logic [SGL_FRAC_W-1:0] s_frac;
  logic                  s_carry, s_inx;

  logic                  sel_carry, sel_inx;
  logic [DBL_FRAC_W-1:0] sel_frac;
  logic [EXP_W-1:0]      exp_b;
  logic [63:0]           calc_res;
  logic                  calc_inx;

  logic                  nx_valid, nx_inx, nx_zero, nx_neg;
  logic [63:0]           nx_res;

  assign rm = rmode_e'(rmode);

  i2f_prep #(.W(XLEN)) u_prep (
    .op(operand), .wide(src_wide), .sgn(src_signed), .mag(mag), .neg(neg)
  );

  i2f_lzc #(.W(XLEN), .CW(CNT_W)) u_lzc (.vec(mag), .cnt(lz));

  assign norm    = mag << lz;
  assign is_zero = (mag == '0);

  i2f_round #(.W(XLEN), .P(DBL_SIG_W)) u_rnd_dbl (
    .norm(norm), .neg(neg), .rm(rm),
    .frac(d_frac), .carry(d_carry), .inexact(d_inx)
  );

  i2f_round #(.W(XLEN), .P(SGL_SIG_W)) u_rnd_sgl (
    .norm(norm), .neg(neg), .rm(rm),
    .frac(s_frac), .carry(s_carry), .inexact(s_inx)
  );

  // Result assembly
  always_comb begin
    sel_carry = dst_single ? s_carry : d_carry;
    sel_inx   = dst_single ? s_inx : d_inx;
    sel_frac  = dst_single ? {s_frac, {PAD_W{1'b0}}} : d_frac;
    exp_b     = EXP_W'(EXP_BIAS + XLEN - 1) - EXP_W'(lz) + EXP_W'(sel_carry);
    if (is_zero) begin
      calc_res = '0;
      calc_inx = 1'b0;
    end else begin
      calc_res = {neg, exp_b, sel_frac};
      calc_inx = sel_inx;
    end
  end

  // Next state with explicit enable
  always_comb begin
    nx_valid = in_valid;
    nx_res   = result;
    nx_inx   = out_inexact;
    nx_zero  = out_zero;
    nx_neg   = out_neg;
    if (in_valid) begin
      nx_res  = calc_res;
      nx_inx  = calc_inx;
      nx_zero = is_zero;
      nx_neg  = ~is_zero & neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      result      <= '0;
      out_inexact <= 1'b0;
      out_zero    <= 1'b0;
      out_neg     <= 1'b0;
    end else begin
      out_valid   <= nx_valid;
      result      <= nx_res;
      out_inexact <= nx_inx;
      out_zero    <= nx_zero;
      out_neg     <= nx_neg;
    end
  end
endmodule

// File: rtl/i2f_conv_chk.sv
module i2f_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] operand,
  input logic        src_wide,
  input logic        src_signed,
  input logic        dst_single,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        out_inexact,
  input logic        out_zero,
  input logic        out_neg
);
  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(out_inexact) && $stable(out_zero));
  // R7
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (src_wide ? (operand == 64'd0) : (operand[31:0] == 32'd0))
    |=> (result == 64'd0) && !out_inexact && out_zero);
  // R5
  single_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && dst_single |=> result[28:0] == 29'd0);
  // R3
  unsigned_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !src_signed |=> !result[63]);
  // R8
  exact_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !src_wide && !dst_single |=> !out_inexact);
  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (result == 64'd0));
  // R9
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_neg == result[63]);
  // R10
  exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_zero |-> (result[62:52] >= 11'd1023) && (result[62:52] <= 11'd1087));
endmodule

bind i2f_conv i2f_conv_chk u_i2f_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
  .src_wide(src_wide), .src_signed(src_signed), .dst_single(dst_single),
  .out_valid(out_valid), .result(result), .out_inexact(out_inexact),
  .out_zero(out_zero), .out_neg(out_neg)
);

// File: tb/test_i2f_conv.sv
`timescale 1ns/1ps
module test_i2f_conv;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic        src_wide, src_signed, dst_single;
  logic [1:0]  rmode;
  logic        out_valid;
  logic [63:0] result;
  logic        out_inexact, out_zero, out_neg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  i2f_conv i_i2f_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .src_wide(src_wide), .src_signed(src_signed), .dst_single(dst_single),
    .rmode(rmode), .out_valid(out_valid), .result(result),
    .out_inexact(out_inexact), .out_zero(out_zero), .out_neg(out_neg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic model: quotient and remainder against the half unit
  function automatic void ref_conv(input logic [63:0] op, input bit wide, input bit sgn,
                                   input bit sgl, input bit [1:0] rm,
                                   output logic [63:0] res, output bit inx, output bit ng);
    logic [63:0] v, mag, sig, rem, half;
    int m, p, sh;
    bit up;
    v   = wide ? op : (sgn ? {{32{op[31]}}, op[31:0]} : {32'h0, op[31:0]});
    ng  = sgn && v[63];
    mag = ng ? (64'd0 - v) : v;
    res = '0;
    inx = 1'b0;
    if (mag == 64'd0) begin
      ng = 1'b0;
      return;
    end
    m = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) m = i;
    p = sgl ? 24 : 53;
    if (m < p) begin
      sig  = mag << (p - 1 - m);
      rem  = '0;
      half = '0;
    end else begin
      sh   = m - p + 1;
      sig  = mag >> sh;
      rem  = mag - (sig << sh);
      half = 64'd1 << (sh - 1);
    end
    inx = (rem != 64'd0);
    case (rm)
      2'd0:    up = inx && ((rem > half) || (rem == half && sig[0]));
      2'd1:    up = 1'b0;
      2'd2:    up = inx && !ng;
      default: up = inx && ng;
    endcase
    sig = sig + 64'(up);
    if (sig == (64'd1 << p)) begin
      sig = 64'd1 << (p - 1);
      m++;
    end
    res[63]    = ng;
    res[62:52] = 11'(m + 1023);
    res[51:0]  = sgl ? {sig[22:0], 29'd0} : sig[51:0];
  endfunction

  task automatic run(logic [63:0] op, bit wide, bit sgn, bit sgl, bit [1:0] rm);
    logic [63:0] er;
    bit ei, en;
    string tag;
    @(negedge clk);
    operand = op; src_wide = wide; src_signed = sgn; dst_single = sgl; rmode = rm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    ref_conv(op, wide, sgn, sgl, rm, er, ei, en);
    tag = (rm != 2'd0) ? "R6" : (sgl ? "R5" : "R4");
    chk("R1 valid", 64'(out_valid), 64'd1);
    chk(tag, result, er);
    chk("R8 inexact", 64'(out_inexact), 64'(ei));
    chk("R9 zero", 64'(out_zero), 64'(er == 64'd0));
    chk("R9 neg", 64'(out_neg), 64'(en));
    if (wide && sgn && !sgl && rm == 2'd0)
      chk("R4 real", result, $realtobits(real'($signed(op))));
  endtask

  function automatic logic [63:0] edge_vec(int i);
    case (i)
      0:  return 64'd0;
      1:  return 64'd1;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h7FFF_FFFF_FFFF_FFFF;
      4:  return 64'h8000_0000_0000_0000;
      5:  return 64'h0000_0000_7FFF_FFFF;
      6:  return 64'h0000_0000_8000_0000;
      7:  return 64'h0000_0000_FFFF_FFFF;
      8:  return 64'h0000_0000_0100_0001;
      9:  return 64'h0000_0000_0100_0003;
      10: return 64'h0000_0000_FEFF_FFFF;
      11: return 64'h0020_0000_0000_0001;
      12: return 64'h0020_0000_0000_0003;
      13: return 64'h003F_FFFF_FFFF_FFFF;
      14: return 64'hFFE0_0000_0000_0001;
      15: return 64'hDEAD_BEEF_0000_0005;
      16: return 64'hFFFF_FFFF_0000_0000;
      17: return 64'h0000_0000_0180_0000;
      18: return 64'h0000_0000_FFFF_FF80;
      19: return 64'h0000_0000_FFFF_FF7F;
      20: return 64'h1234_5678_9ABC_DEF0;
      21: return 64'h8000_0000_0000_0001;
      22: return 64'h0000_0000_0000_0400;
      default: return 64'hFF80_0000_0000_0001;
    endcase
  endfunction

  task automatic sweep(logic [63:0] op);
    for (int k = 0; k < 32; k++) begin
      run(op, k[4], k[3], k[2], k[1:0]);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0;
    src_wide = 1'b0; src_signed = 1'b0; dst_single = 1'b0; rmode = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle valid", 64'(out_valid), 64'd0);

    // R2: upper half ignored for narrow source
    run(64'hDEAD_BEEF_0000_0005, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R2 upper ignored", result, 64'h4014_0000_0000_0000);
    // R3: signed vs unsigned reading of the same bits
    run(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 2'd0);
    chk("R3 signed -1", result, 64'hBFF0_0000_0000_0000);
    run(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 2'd0);
    chk("R3 unsigned max", result, 64'h41EF_FFFF_FFE0_0000);
    // R10: carry into exponent, and toward zero keeps it below
    run(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd0);
    chk("R10 carry", result, 64'h43F0_0000_0000_0000);
    chk("R8 carry inexact", 64'(out_inexact), 64'd1);
    run(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 2'd1);
    chk("R6 rtz max", result, 64'h43EF_FFFF_FFFF_FFFF);
    // R5/R6: single precision around 2^24
    run(64'd16777217, 1'b0, 1'b0, 1'b1, 2'd0);
    chk("R5 tie even down", result, 64'h4170_0000_0000_0000);
    run(64'd16777219, 1'b0, 1'b0, 1'b1, 2'd0);
    chk("R5 tie even up", result, 64'h4170_0000_4000_0000);
    run(64'd16777217, 1'b0, 1'b0, 1'b1, 2'd2);
    chk("R6 toward +inf", result, 64'h4170_0000_2000_0000);
    run(64'hFFFF_FFFF_FEFF_FFFF, 1'b1, 1'b1, 1'b1, 2'd3);
    chk("R6 toward -inf neg", result, 64'hC170_0000_2000_0000);
    run(64'hFFFF_FFFF_FEFF_FFFF, 1'b1, 1'b1, 1'b1, 2'd2);
    chk("R6 toward +inf neg", result, 64'hC170_0000_0000_0000);
    // R7: zero, including a narrow source with garbage above
    run(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b0, 2'd3);
    chk("R7 zero result", result, 64'd0);
    chk("R7 zero flag", 64'(out_zero), 64'd1);
    // R11: hold while idle
    run(64'd7, 1'b1, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    operand = 64'd99; rmode = 2'd2;
    @(negedge clk);
    chk("R11 hold result", result, 64'h401C_0000_0000_0000);
    chk("R1 idle after", 64'(out_valid), 64'd0);

    for (int i = 0; i < 24; i++) sweep(edge_vec(i));
    for (int i = 0; i < 100; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      sweep(rng >> rng[5:0]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule